// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits between the pins of an SPI slave and its serial core. It resamples chip select, the serial clock, the pause pin and the serial input on a free-running system clock. It then turns serial-clock edges into single-cycle enables for the core. While the pause pin holds the link, it stops those enables and floats the serial output. If the host deselects the device in the middle of a pause, it resets the core's command logic and locks the interface.

A pause is entered or left only while the resampled serial clock is low. A pause-pin edge that arrives while the clock is high takes effect at the next low level of the clock. The core only ever sees enabled edges, so after a pause it continues at the exact bit position it had reached. Timers for internal program, erase or status-write work are outside this block, and nothing here touches them.

Top module: `hold_guard`

## Requirements
- R1: During reset and right after it, coreRst is 1, coreRiseEn and coreFallEn are 0, and soPadOe is 0.
- R2: With csN low, holdN high and no lockout, each rising sclk edge gives exactly one coreRiseEn pulse and each falling edge gives one coreFallEn pulse. The two are never high together, and coreSi during a coreRiseEn pulse equals the si level that was applied at that rising edge.
- R3: While a pause is active, coreRiseEn, coreFallEn and soPadOe stay 0, whatever sclk and si do.
- R4: A holdN fall while csN is low and sclk is low starts the pause at once. A holdN fall while sclk is high starts it only when sclk goes low, and that falling sclk edge still produces its coreFallEn.
- R5: A holdN rise while sclk is low ends the pause. A holdN rise while sclk is high ends it only when sclk goes low, and that falling sclk edge gives no coreFallEn. This also holds when the holdN rise and the sclk fall arrive together.
- R6: soPadOe equals coreSoOe whenever csN is low, no pause is active and the interface is not locked; otherwise it is 0. soPadData always follows coreSo.
- R7: csN rising during a pause sets coreRst to 1 and locks the interface. The lock stays, with coreRst at 1 and no enables, through any later csN fall, until csN and holdN are both seen high.
- R8: After a lockout is cleared (holdN high, then csN high), the next csN fall starts a normal transaction with coreRst at 0.
- R9: Across any pause, placed after any bit of a byte, the core receives exactly the 8 transmitted bits in order, with none lost or repeated.
- R10: While csN is high, coreRst is 1 and no enables are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select pin, active low |
| sclk | input | 1 | Serial clock pin |
| holdN | input | 1 | Pause pin, active low |
| si | input | 1 | Serial data input pin |
| coreSo | input | 1 | Serial output bit from the core |
| coreSoOe | input | 1 | Output enable requested by the core |
| coreRiseEn | output | 1 | One-cycle enable for a qualified rising sclk edge |
| coreFallEn | output | 1 | One-cycle enable for a qualified falling sclk edge |
| coreSi | output | 1 | Resampled serial input, aligned with the enables |
| soPadOe | output | 1 | Output-pad enable for the serial output |
| soPadData | output | 1 | Output-pad data for the serial output |
| coreRst | output | 1 | Reset for the core's command logic |

## Verification
Two things can land in the same sample: the release of a pause and a falling serial-clock edge. The bench provokes this by moving holdN high and sclk low in the same system-clock cycle, and also tests release with sclk steadily low and release while sclk is high. For each case it checks that the falling edge is swallowed, that the next rising edge counts, and that the byte assembled from the enables matches the byte sent. The sweep covers every bit position for the pause, both pause-entry phases and all three release timings.

// File: rtl/hold_pkg.sv
package hold_pkg;

  // Interface state kept by the control module
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HELD   = 2'd1,
    ST_LOCKED = 2'd2
  } holdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic held;       // pause active
    logic resetCore;  // deselected or locked out
  } holdStb_t;

  // Bit positions inside the resampled pin vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_HOLD = 1;
  localparam int PIN_CS   = 2;
  localparam int PIN_SI   = 3;
  localparam int PIN_CNT  = 4;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[g] <= INIT;
          else       stg[g] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[g] <= INIT;
          else       stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csLvl,
  input  logic     holdLvl,
  input  logic     sclkLvl,
  output holdStb_t stb
);

  holdState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (!csLvl && !holdLvl && !sclkLvl) stateNext = ST_HELD;
      end
      ST_HELD: begin
        if (csLvl)                        stateNext = ST_LOCKED;
        else if (holdLvl && !sclkLvl)     stateNext = ST_RUN;
      end
      ST_LOCKED: begin
        if (csLvl && holdLvl)             stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign stb.held      = (state == ST_HELD);
  assign stb.resetCore = (state == ST_LOCKED) || csLvl;

endmodule

// File: rtl/hold_dpath.sv
module hold_dpath
  import hold_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkLvl,
  input  logic     siLvl,
  input  logic     coreSo,
  input  logic     coreSoOe,
  input  holdStb_t stb,
  output logic     coreRiseEn,
  output logic     coreFallEn,
  output logic     coreSi,
  output logic     soPadOe,
  output logic     soPadData,
  output logic     coreRst
);

  logic sclkPrev;
  logic freeze;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkLvl;
  end

  assign freeze     = stb.held | stb.resetCore;
  assign coreRiseEn = sclkLvl & ~sclkPrev & ~freeze;
  assign coreFallEn = ~sclkLvl & sclkPrev & ~freeze;
  assign coreSi     = siLvl;
  assign soPadOe    = coreSoOe & ~freeze;
  assign soPadData  = coreSo;
  assign coreRst    = stb.resetCore;

endmodule

// File: rtl/hold_guard.sv
module hold_guard
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic holdN,
  input  logic si,
  input  logic coreSo,
  input  logic coreSoOe,
  output logic coreRiseEn,
  output logic coreFallEn,
  output logic coreSi,
  output logic soPadOe,
  output logic soPadData,
  output logic coreRst
);

  localparam logic [PIN_CNT-1:0] PIN_INIT =
    PIN_CNT'((1 << PIN_HOLD) | (1 << PIN_CS));

  logic [PIN_CNT-1:0] pinRaw, pinLvl;
  logic csLvl, sclkLvl, holdLvl, siLvl;
  holdStb_t stb;

  always_comb begin
    pinRaw           = '0;
    pinRaw[PIN_SCLK] = sclk;
    pinRaw[PIN_HOLD] = holdN;
    pinRaw[PIN_CS]   = csN;
    pinRaw[PIN_SI]   = si;
  end

  hold_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .INIT(PIN_INIT)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinRaw), .dout(pinLvl)
  );

  assign sclkLvl = pinLvl[PIN_SCLK];
  assign holdLvl = pinLvl[PIN_HOLD];
  assign csLvl   = pinLvl[PIN_CS];
  assign siLvl   = pinLvl[PIN_SI];

  hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csLvl(csLvl), .holdLvl(holdLvl),
    .sclkLvl(sclkLvl), .stb(stb)
  );

  hold_dpath u_dpath (
    .clk(clk), .rstN(rstN), .sclkLvl(sclkLvl), .siLvl(siLvl),
    .coreSo(coreSo), .coreSoOe(coreSoOe), .stb(stb),
    .coreRiseEn(coreRiseEn), .coreFallEn(coreFallEn), .coreSi(coreSi),
    .soPadOe(soPadOe), .soPadData(soPadData), .coreRst(coreRst)
  );

endmodule

// File: rtl/hold_guard_chk.sv
module hold_guard_chk (
  input logic clk,
  input logic rstN,
  input logic coreRiseEn,
  input logic coreFallEn,
  input logic coreRst,
  input logic soPadOe,
  input logic coreSoOe,
  input logic held,
  input logic csLvl,
  input logic sclkLvl
);

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(coreRiseEn && coreFallEn)); // R2

  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    held |-> (!coreRiseEn && !coreFallEn && !soPadOe)); // R3

  AST_ENTRY_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(held) |-> !$past(sclkLvl)); // R4

  AST_EXIT_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(held) && !$past(csLvl)) |-> !$past(sclkLvl)); // R5

  AST_PAD_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rstN)
    soPadOe |-> coreSoOe); // R6

  AST_RST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |-> (!coreRiseEn && !coreFallEn && !soPadOe)); // R7

  AST_DESEL_RST: assert property (@(posedge clk) disable iff (!rstN)
    csLvl |-> coreRst); // R10

endmodule

bind hold_guard hold_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .coreRiseEn(coreRiseEn), .coreFallEn(coreFallEn),
  .coreRst(coreRst), .soPadOe(soPadOe), .coreSoOe(coreSoOe),
  .held(stb.held), .csLvl(csLvl), .sclkLvl(sclkLvl)
);

// File: tb/sim_hold_guard.sv
module sim_hold_guard;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, holdN = 1'b1, si = 1'b0;
  logic coreSo = 1'b0, coreSoOe = 1'b0;
  logic coreRiseEn, coreFallEn, coreSi, soPadOe, soPadData, coreRst;

  int riseCnt = 0, fallCnt = 0;
  logic [7:0] siShift = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_guard u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .holdN(holdN), .si(si),
    .coreSo(coreSo), .coreSoOe(coreSoOe), .coreRiseEn(coreRiseEn),
    .coreFallEn(coreFallEn), .coreSi(coreSi), .soPadOe(soPadOe),
    .soPadData(soPadData), .coreRst(coreRst)
  );

  always @(posedge clk) begin
    if (coreRiseEn) begin
      riseCnt <= riseCnt + 1;
      siShift <= {siShift[6:0], coreSi};
    end
    if (coreFallEn) fallCnt <= fallCnt + 1;
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(bit b);
    si = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
  endtask

  task automatic garbageToggles(int n);
    for (int k = 0; k < n; k++) begin
      si = ~si;
      waitClk(HALF);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
  endtask

  // pause body: checks silence, toggles, then releases in one of three ways
  task automatic pauseBody(int endMode);
    int r0, f0;
    waitClk(HALF);
    check(soPadOe == 1'b0, "R3/R6 pad floated in pause", int'(soPadOe), 0);
    r0 = riseCnt; f0 = fallCnt;
    garbageToggles(3);
    check(riseCnt == r0 && fallCnt == f0, "R3 edges ignored in pause",
          riseCnt - r0 + fallCnt - f0, 0);
    case (endMode)
      0: begin holdN = 1'b1; waitClk(HALF); end
      1: begin
        sclk = 1'b1; waitClk(HALF);
        holdN = 1'b1; waitClk(HALF);
        sclk = 1'b0; waitClk(HALF);
      end
      default: begin
        sclk = 1'b1; waitClk(HALF);
        holdN = 1'b1; sclk = 1'b0; waitClk(HALF);
      end
    endcase
  endtask

  task automatic pausedByte(logic [7:0] d, int pos, int startMode, int endMode);
    int r0, f0;
    csN = 1'b0;
    waitClk(HALF);
    r0 = riseCnt; f0 = fallCnt;
    for (int i = 0; i < 8; i++) begin
      if (i == pos && startMode == 1) begin
        si = d[7-i];
        waitClk(HALF);
        sclk = 1'b1;
        waitClk(HALF/2);
        holdN = 1'b0;
        waitClk(HALF/2);
        sclk = 1'b0;
        pauseBody(endMode);
      end else begin
        sendBit(d[7-i]);
        if (i == pos && startMode == 0) begin
          waitClk(HALF);
          holdN = 1'b0;
          pauseBody(endMode);
        end
      end
    end
    waitClk(HALF);
    check(riseCnt - r0 == 8, "R9 rise count across pause", riseCnt - r0, 8);
    check(fallCnt - f0 == 8, "R4/R5 fall count across pause", fallCnt - f0, 8);
    check(siShift == d, "R9 byte intact across pause", int'(siShift), int'(d));
    csN = 1'b1;
    waitClk(HALF);
  endtask

  initial begin
    int r0, f0;
    coreSoOe = 1'b1;
    waitClk(3);
    check(coreRst == 1'b1 && soPadOe == 1'b0, "R1 reset outputs",
          int'({coreRst, soPadOe}), 2);
    check(!coreRiseEn && !coreFallEn, "R1 no enables in reset",
          int'({coreRiseEn, coreFallEn}), 0);
    rstN = 1'b1;
    waitClk(4);
    check(coreRst == 1'b1, "R1 coreRst after reset", int'(coreRst), 1);

    // R10: deselected edges ignored
    r0 = riseCnt;
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    waitClk(HALF);
    check(riseCnt == r0 && coreRst, "R10 deselected ignores sclk", riseCnt - r0, 0);

    // R2 / R6: plain byte and pad follow
    csN = 1'b0;
    waitClk(HALF);
    check(coreRst == 1'b0, "R8 selected releases reset", int'(coreRst), 0);
    check(soPadOe == 1'b1, "R6 pad enable follows core", int'(soPadOe), 1);
    coreSo = 1'b1; waitClk(1);
    check(soPadData == 1'b1, "R6 pad data one", int'(soPadData), 1);
    coreSo = 1'b0; waitClk(1);
    check(soPadData == 1'b0, "R6 pad data zero", int'(soPadData), 0);
    coreSoOe = 1'b0; waitClk(1);
    check(soPadOe == 1'b0, "R6 pad off when core off", int'(soPadOe), 0);
    coreSoOe = 1'b1;
    r0 = riseCnt; f0 = fallCnt;
    for (int i = 0; i < 8; i++) sendBit(8'hC3 >> (7 - i));
    waitClk(HALF);
    check(riseCnt - r0 == 8 && fallCnt - f0 == 8, "R2 one enable per edge",
          riseCnt - r0 + fallCnt - f0, 16);
    check(siShift == 8'hC3, "R2 data sampled on rise", int'(siShift), 8'hC3);
    csN = 1'b1;
    waitClk(HALF);

    // R4 R5 R9 sweep
    for (int sm = 0; sm < 2; sm++)
      for (int em = 0; em < 3; em++)
        for (int p = 0; p < 8; p++)
          pausedByte(8'((p * 29 + sm * 83 + em * 151) ^ 8'hA5), p, sm, em);

    // R7: deselect during pause, lock persists
    csN = 1'b0;
    waitClk(HALF);
    sendBit(1'b1); sendBit(1'b0);
    waitClk(HALF);
    holdN = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
    check(coreRst == 1'b1, "R7 reset on deselect in pause", int'(coreRst), 1);
    csN = 1'b0;
    waitClk(HALF);
    check(coreRst == 1'b1, "R7 lock holds with holdN low", int'(coreRst), 1);
    holdN = 1'b1;
    waitClk(HALF);
    check(coreRst == 1'b1, "R7 lock holds after holdN rise", int'(coreRst), 1);
    r0 = riseCnt;
    garbageToggles(3);
    check(riseCnt == r0 && soPadOe == 1'b0, "R7 no enables while locked",
          riseCnt - r0, 0);

    // R8: clear lock, fresh transaction
    csN = 1'b1;
    waitClk(HALF);
    csN = 1'b0;
    waitClk(HALF);
    check(coreRst == 1'b0, "R8 fresh select clears lock", int'(coreRst), 0);
    r0 = riseCnt;
    for (int i = 0; i < 8; i++) sendBit(8'h3E >> (7 - i));
    waitClk(HALF);
    check(riseCnt - r0 == 8 && siShift == 8'h3E, "R8 normal byte after lock",
          int'(siShift), 8'h3E);
    csN = 1'b1;
    waitClk(HALF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule